// File: doc/BRIEF.md
# Fixed-Length Packet Framing Checker

This block watches the stream of flit type tags entering one switch input and checks, cycle by cycle, that they form packets of a fixed length. A packet is always a head flit, a fixed number of data flits and a closing tail flit, `FPP` flits in total. The number of data flits is `FPP-2`. A packet may begin in any cycle, and cycles where the valid qualifier is low are skipped without affecting the count.

When a tail flit closes a correctly framed packet, the checker raises `pkt_ok` for one cycle. Any framing violation raises `err_pulse` for one cycle, together with a cause code. The violations are a stray flit outside a packet, a head arriving inside an open packet, a packet of the wrong length, and a reserved tag value. Both pulses are registered and appear in the cycle after the flit that caused them. The block inspects only the tags and does not look at payload or route information.

Top module: `flit_frame_checker`

## Requirements
- R1: During and right after synchronous reset (`rst` high), `err_pulse`, `err_cause` and `pkt_ok` are 0, and no packet is open.
- R2: A head (tag 01), then `FPP-2` data flits (tag 00), then a tail (tag 10), all with `flit_valid` high, give `pkt_ok`=1 in the cycle after the tail and no error at any point.
- R3: A data (00) or tail (10) flit while no packet is open gives `err_pulse`=1 with cause 00, an orphan flit, and the checker stays idle.
- R4: A head (01) while a packet is open gives `err_pulse`=1 with cause 01, a premature head. Counting then restarts, so the new head begins a packet that completes after `FPP-1` further flits.
- R5: A tail arriving before flit position `FPP`, or a data flit arriving where the tail is due, gives `err_pulse`=1 with cause 10, a length error. The packet is closed, so a following tail is an orphan.
- R6: Tag 11 always gives `err_pulse`=1 with cause 11, an illegal tag. It aborts an open packet and is discarded when the checker is idle.
- R7: A cycle with `flit_valid` low has no effect: no pulse follows it, and the position inside an open packet is held.
- R8: A packet may start in any cycle, including the cycle right after a tail. Back-to-back packets each produce their own `pkt_ok`.
- R9: Each pulse lasts one cycle and is registered, appearing one cycle after the flit that caused it. `err_pulse` and `pkt_ok` are never high together, and `err_cause` is 00 whenever `err_pulse` is low.
- R10: `FPP` below 2 is rejected at elaboration. With `FPP`=2 a head followed directly by a tail is a complete packet, and a data flit after a head is a length error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flit_valid | input | 1 | Qualifies `flit_tag` in this cycle |
| flit_tag | input | 2 | Flit type: 01 head, 00 data, 10 tail, 11 illegal |
| err_pulse | output | 1 | One-cycle framing violation pulse |
| err_cause | output | 2 | Violation cause: 00 orphan, 01 premature head, 10 length, 11 illegal tag |
| pkt_ok | output | 1 | One-cycle pulse for a correctly framed packet |

## Verification
The bench builds two instances from the same stimulus: one with `FPP`=4 and one with `FPP`=2, the shortest legal length. Every sequence of five cycles is swept from reset. Each cycle is one of the four tags or an idle cycle carrying a head tag. This covers every transition into, through and out of a four-flit packet: early and late tails, a head at each position, an illegal tag at each position, and idle gaps at each position. The same sweep exercises the degenerate two-flit packet, in which the tail is due immediately after the head.

// File: rtl/flit_frame_pkg.sv
package flit_frame_pkg;

  typedef enum logic [1:0] {
    TAG_DATA = 2'b00,
    TAG_HEAD = 2'b01,
    TAG_TAIL = 2'b10,
    TAG_BAD  = 2'b11
  } flit_tag_e;

  typedef enum logic [1:0] {
    CAUSE_ORPHAN    = 2'b00,
    CAUSE_PREMATURE = 2'b01,
    CAUSE_LENGTH    = 2'b10,
    CAUSE_ILLEGAL   = 2'b11
  } frame_cause_e;

  typedef enum logic [1:0] {
    ACT_HOLD,
    ACT_START,
    ACT_ADVANCE,
    ACT_CLOSE
  } track_act_e;

  typedef struct packed {
    logic head;
    logic tail;
    logic data;
    logic bad;
  } flit_class_t;

  // Width that can hold positions 0 .. fpp-1.
  function automatic int pos_width(input int fpp);
    int w;
    w = $clog2(fpp);
    return (w < 1) ? 1 : w;
  endfunction

  // Position index at which the tail is due.
  function automatic int last_pos(input int fpp);
    return fpp - 1;
  endfunction

endpackage

// File: rtl/flit_tag_decode.sv
module flit_tag_decode
  import flit_frame_pkg::*;
(
  input  logic        valid,
  input  logic [1:0]  tag,
  output flit_class_t cls
);

  always_comb begin
    cls = '0;
    if (valid) begin
      unique case (flit_tag_e'(tag))
        TAG_HEAD: cls.head = 1'b1;
        TAG_TAIL: cls.tail = 1'b1;
        TAG_DATA: cls.data = 1'b1;
        default:  cls.bad  = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/flit_pos_tracker.sv
module flit_pos_tracker
  import flit_frame_pkg::*;
#(
  parameter int FPP = 4,
  parameter int PW  = pos_width(FPP)
) (
  input  logic          clk,
  input  logic          rst,
  input  track_act_e    act,
  output logic          pkt_open,
  output logic [PW-1:0] pos,
  output logic          at_last
);

  localparam logic [PW-1:0] LAST = PW'(last_pos(FPP));
  localparam logic [PW-1:0] ONE  = PW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_open <= 1'b0;
      pos      <= '0;
    end else begin
      unique case (act)
        ACT_START: begin
          pkt_open <= 1'b1;
          pos      <= ONE;
        end
        ACT_ADVANCE: pos <= pos + ONE;
        ACT_CLOSE: begin
          pkt_open <= 1'b0;
          pos      <= '0;
        end
        default: ;
      endcase
    end
  end

  assign at_last = (pos == LAST);

endmodule

// File: rtl/flit_frame_judge.sv
module flit_frame_judge
  import flit_frame_pkg::*;
(
  input  flit_class_t  cls,
  input  logic         pkt_open,
  input  logic         at_last,
  output track_act_e   act,
  output logic         err,
  output frame_cause_e cause,
  output logic         ok
);

  always_comb begin
    act   = ACT_HOLD;
    err   = 1'b0;
    cause = CAUSE_ORPHAN;
    ok    = 1'b0;
    if (cls.bad) begin
      err   = 1'b1;
      cause = CAUSE_ILLEGAL;
      act   = pkt_open ? ACT_CLOSE : ACT_HOLD;
    end else if (cls.head) begin
      act = ACT_START;
      if (pkt_open) begin
        err   = 1'b1;
        cause = CAUSE_PREMATURE;
      end
    end else if (cls.tail) begin
      if (!pkt_open) begin
        err   = 1'b1;
        cause = CAUSE_ORPHAN;
      end else if (at_last) begin
        ok  = 1'b1;
        act = ACT_CLOSE;
      end else begin
        err   = 1'b1;
        cause = CAUSE_LENGTH;
        act   = ACT_CLOSE;
      end
    end else if (cls.data) begin
      if (!pkt_open) begin
        err   = 1'b1;
        cause = CAUSE_ORPHAN;
      end else if (at_last) begin
        err   = 1'b1;
        cause = CAUSE_LENGTH;
        act   = ACT_CLOSE;
      end else begin
        act = ACT_ADVANCE;
      end
    end
  end

endmodule

// File: rtl/flit_frame_checker.sv
module flit_frame_checker
  import flit_frame_pkg::*;
#(
  parameter int FPP = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       flit_valid,
  input  logic [1:0] flit_tag,
  output logic       err_pulse,
  output logic [1:0] err_cause,
  output logic       pkt_ok
);

  localparam int PW = pos_width(FPP);

  if (FPP < 2) begin : g_fpp_reject
    $error("flit_frame_checker: FPP must be at least 2");
  end

  flit_class_t  cls;
  track_act_e   act;
  logic         pkt_open;
  logic [PW-1:0] pos;
  logic         at_last;
  logic         judge_err;
  frame_cause_e judge_cause;
  logic         judge_ok;

  // Named internal events for the assertions.
  logic ev_start;
  logic ev_close;
  assign ev_start = (act == ACT_START);
  assign ev_close = (act == ACT_CLOSE);

  flit_tag_decode u_decode (
    .valid (flit_valid),
    .tag   (flit_tag),
    .cls   (cls)
  );

  flit_pos_tracker #(.FPP(FPP), .PW(PW)) u_track (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .pkt_open (pkt_open),
    .pos      (pos),
    .at_last  (at_last)
  );

  flit_frame_judge u_judge (
    .cls      (cls),
    .pkt_open (pkt_open),
    .at_last  (at_last),
    .act      (act),
    .err      (judge_err),
    .cause    (judge_cause),
    .ok       (judge_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_pulse <= 1'b0;
      err_cause <= 2'b00;
      pkt_ok    <= 1'b0;
    end else begin
      err_pulse <= judge_err;
      err_cause <= judge_err ? 2'(judge_cause) : 2'b00;
      pkt_ok    <= judge_ok;
    end
  end

endmodule

// File: rtl/flit_frame_checker_sva.sv
module flit_frame_checker_sva
  import flit_frame_pkg::*;
#(
  parameter int FPP = 4,
  parameter int PW  = pos_width(FPP)
) (
  input logic          clk,
  input logic          rst,
  input logic          flit_valid,
  input logic [1:0]    flit_tag,
  input logic          err_pulse,
  input logic [1:0]    err_cause,
  input logic          pkt_ok,
  input logic          pkt_open,
  input logic [PW-1:0] pos,
  input logic          ev_start,
  input logic          ev_close
);

  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(err_pulse && pkt_ok));

  p_quiet_cause_r9: assert property (@(posedge clk) disable iff (rst)
    !err_pulse |-> err_cause == 2'b00);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !flit_valid |=> !err_pulse && !pkt_ok && $stable(pos) && $stable(pkt_open));

  p_orphan_r3: assert property (@(posedge clk) disable iff (rst)
    !pkt_open && flit_valid && (flit_tag == 2'b00 || flit_tag == 2'b10)
    |=> err_pulse && err_cause == 2'b00 && !pkt_open);

  p_prem_restart_r4: assert property (@(posedge clk) disable iff (rst)
    pkt_open && flit_valid && flit_tag == 2'b01
    |=> err_pulse && err_cause == 2'b01 && pkt_open && pos == PW'(1));

  p_illegal_r6: assert property (@(posedge clk) disable iff (rst)
    flit_valid && flit_tag == 2'b11
    |=> err_pulse && err_cause == 2'b11 && !pkt_open);

  p_ok_after_tail_r2: assert property (@(posedge clk) disable iff (rst)
    pkt_ok |-> $past(flit_valid && flit_tag == 2'b10) && !pkt_open);

  p_start_opens_r8: assert property (@(posedge clk) disable iff (rst)
    ev_start |=> pkt_open);

  p_close_idles_r5: assert property (@(posedge clk) disable iff (rst)
    ev_close |=> !pkt_open && pos == '0);

  p_pos_range_r2: assert property (@(posedge clk) disable iff (rst)
    int'(pos) <= FPP - 1);

endmodule

bind flit_frame_checker flit_frame_checker_sva #(.FPP(FPP), .PW(PW)) u_sva (
  .clk        (clk),
  .rst        (rst),
  .flit_valid (flit_valid),
  .flit_tag   (flit_tag),
  .err_pulse  (err_pulse),
  .err_cause  (err_cause),
  .pkt_ok     (pkt_ok),
  .pkt_open   (pkt_open),
  .pos        (pos),
  .ev_start   (ev_start),
  .ev_close   (ev_close)
);

// File: tb/tb_flit_frame_checker.sv
`timescale 1ns/1ps
module tb_flit_frame_checker;

  localparam int LONG_FPP  = 4;
  localparam int SHORT_FPP = 2;
  localparam int SEQ_LEN   = 5;
  localparam int WATCHDOG  = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic v   = 1'b0;
  logic [1:0] tg = 2'b00;

  logic       e_l, ok_l, e_s, ok_s;
  logic [1:0] c_l, c_s;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Reference state for both instances.
  bit open_l, open_s;
  int seen_l, seen_s;

  always #10 clk = ~clk;

  flit_frame_checker #(.FPP(LONG_FPP)) dut (
    .clk(clk), .rst(rst), .flit_valid(v), .flit_tag(tg),
    .err_pulse(e_l), .err_cause(c_l), .pkt_ok(ok_l)
  );

  flit_frame_checker #(.FPP(SHORT_FPP)) dut_short (
    .clk(clk), .rst(rst), .flit_valid(v), .flit_tag(tg),
    .err_pulse(e_s), .err_cause(c_s), .pkt_ok(ok_s)
  );

  task automatic summary_and_end();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected below %0d", cycles, WATCHDOG);
      summary_and_end();
    end
  end

  // Requirement-level model: counts flits seen in the open packet.
  task automatic model(input int fpp, input bit vv, input logic [1:0] t,
                       inout bit open, inout int seen,
                       output bit ee, output logic [1:0] cc, output bit oo,
                       output string req);
    ee = 0; cc = 2'b00; oo = 0; req = "R7";
    if (!vv) return;
    if (t == 2'b11) begin
      ee = 1; cc = 2'b11; req = "R6"; open = 0; seen = 0;
    end else if (t == 2'b01) begin
      if (open) begin ee = 1; cc = 2'b01; req = "R4"; end
      else req = "R8";
      open = 1; seen = 1;
    end else if (!open) begin
      ee = 1; cc = 2'b00; req = "R3";
    end else begin
      seen = seen + 1;
      if (t == 2'b10) begin
        if (seen == fpp) begin oo = 1; req = "R2"; end
        else begin ee = 1; cc = 2'b10; req = "R5"; end
        open = 0; seen = 0;
      end else if (seen == fpp) begin
        ee = 1; cc = 2'b10; req = "R5"; open = 0; seen = 0;
      end else req = "R2";
    end
  endtask

  task automatic compare(input string req, input logic ae, input logic [1:0] ac,
                         input logic ao, input bit xe, input logic [1:0] xc,
                         input bit xo);
    checks = checks + 1;
    if (ae !== xe || ac !== xc || ao !== xo) begin
      errors = errors + 1;
      $display("FAIL %s: actual err=%b cause=%b ok=%b, expected err=%b cause=%b ok=%b",
               req, ae, ac, ao, xe, xc, xo);
    end
  endtask

  // Drive at the falling edge, sample at the next falling edge (R9: one-cycle latency).
  task automatic step(input bit vv, input logic [1:0] t);
    bit xe, xo;
    logic [1:0] xc;
    string rq;
    v = vv; tg = t;
    @(posedge clk);
    @(negedge clk);
    model(LONG_FPP, vv, t, open_l, seen_l, xe, xc, xo, rq);
    compare(rq, e_l, c_l, ok_l, xe, xc, xo);
    model(SHORT_FPP, vv, t, open_s, seen_s, xe, xc, xo, rq);
    compare({rq, "/R10"}, e_s, c_s, ok_s, xe, xc, xo);
  endtask

  task automatic do_reset();
    rst = 1'b1; v = 1'b0; tg = 2'b00;
    @(posedge clk);
    @(negedge clk);
    open_l = 0; seen_l = 0; open_s = 0; seen_s = 0;
    compare("R1", e_l, c_l, ok_l, 0, 2'b00, 0);
    compare("R1", e_s, c_s, ok_s, 0, 2'b00, 0);
    rst = 1'b0;
  endtask

  initial begin
    int ok_count;
    @(negedge clk);
    do_reset();

    // R8: back-to-back packets, each must give its own pkt_ok.
    ok_count = 0;
    for (int k = 0; k < 2; k++) begin
      step(1, 2'b01); step(1, 2'b00); step(1, 2'b00); step(1, 2'b10);
      if (ok_l === 1'b1) ok_count++;
    end
    checks = checks + 1;
    if (ok_count != 2) begin
      errors = errors + 1;
      $display("FAIL R8: actual %0d completions, expected 2", ok_count);
    end

    // R9: pulse lasts only one cycle.
    step(0, 2'b00);
    checks = checks + 1;
    if (ok_l !== 1'b0) begin
      errors = errors + 1;
      $display("FAIL R9: actual ok=%b, expected 0", ok_l);
    end

    // R7: gaps inside a packet hold the position.
    step(1, 2'b01); step(0, 2'b10); step(1, 2'b00); step(0, 2'b11);
    step(1, 2'b00); step(0, 2'b01); step(1, 2'b10);

    // Exhaustive sweep: 5 symbols per cycle (4 tags + idle), 5 cycles.
    for (int s = 0; s < 3125; s++) begin
      int r;
      do_reset();
      r = s;
      for (int k = 0; k < SEQ_LEN; k++) begin
        int sym;
        sym = r % 5;
        r = r / 5;
        if (sym == 4) step(0, 2'b01);
        else step(1, 2'(sym));
      end
    end

    summary_and_end();
  end

endmodule